// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel for a legacy-compatible I/O complex. Software programs it through a byte-wide interface. A control write picks the counting mode or takes a snapshot of the count. Two data writes load the start value, low byte first and then high byte. Two data reads return the live count or the snapshot in the same byte order. Counting advances only on cycles where the `tick` enable is high. In the intended system, `tick` is a strobe at 1,193,180 Hz derived from the fabric clock.

The block supports three modes, all binary:

- **Mode 0:** the output rises once when the count reaches zero.
- **Mode 2:** a periodic rate generator. The output goes low for one count interval per period.
- **Mode 3:** a square wave. The output toggles once per half period.

The channel's output level is also placed in a status byte, so that a system status port can read it. Some control words ask for features the channel does not implement: read-back, BCD counting, single-byte access or other modes. These words are refused and set a sticky error flag.

Top module: `interval_timer_channel`

## Requirements
- R1: A control write is decoded as select = wdata[7:6], access = wdata[5:4], mode = wdata[3:1], bcd = wdata[0]. The word applies only when select equals `CHAN_ID`. Access 3 with mode 0, 2 or 3 and bcd 0 sets the mode, and `cfg_err` stays low.
- R2: `cfg_err` goes high and stays high until reset in any of these cases: a control write with select 3; a control write addressed to this channel with access 1 or 2; mode 1, 4, 5, 6 or 7 with access 3; bcd set with access 3. A refused word leaves the mode unchanged.
- R3: A control word whose select is neither `CHAN_ID` nor 3 has no effect on the channel and does not set `cfg_err`.
- R4: Access 0 is a latch command. When no snapshot is held, it stores the current count, holds the snapshot and points the read pointer at the low byte.
- R5: A latch command that arrives while a snapshot is held is ignored, and the stored value is kept.
- R6: Each data read returns the low byte and then the high byte of the snapshot if one is held, otherwise of the live count. Reading a high byte releases the snapshot.
- R7: A data write aimed at the low byte replaces count bits 7:0, stops counting and drives `out` low.
- R8: A data write aimed at the high byte replaces count bits 15:8, copies the full count to the period register and starts counting only if the value is nonzero. On start, `out` is high in modes 2 and 3 and stays low in mode 0.
- R9: In mode 0, each tick decrements the count. On the tick where the count reaches 0, `out` rises, and it stays high with the count stopped.
- R10: In mode 2, each tick decrements the count. `out` is low exactly while the count holds 1. The tick after that reloads the period and `out` returns high.
- R11: In mode 3, each tick decrements the count by 2. When the count is 2 or less, the next tick instead reloads the period and inverts `out`. An even period N gives N/2 ticks per half; an odd N gives (N+1)/2.
- R12: `status_byte` has bit `STAT_BIT` (default 5) equal to `out` and all other bits 0.
- R13: After reset, `out`, `cfg_err`, `rdata` and `status_byte` are all 0, and both byte pointers select the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one pulse per counting interval |
| ctl_we | input | 1 | Control-word write strobe |
| data_we | input | 1 | Count byte write strobe |
| data_re | input | 1 | Count byte read strobe; advances the read pointer |
| wdata | input | 8 | Write data for control and count writes |
| rdata | output | 8 | Byte currently selected by the read pointer |
| out | output | 1 | Channel output level |
| status_byte | output | 8 | Status-port view of the output level |
| cfg_err | output | 1 | Sticky error flag for refused control words |

## Verification
Every register result is due at the first rising edge after the strobe or tick that causes it. The bench drives each stimulus on a falling edge, holds it across exactly one rising edge, and compares the outputs at the following falling edge. `rdata` is a combinational view of the current pointer, so the bench checks it before it pulses `data_re`. A run of ticks is counted edge by edge, so the expected count and output level after N ticks follow directly from the mode rules.

// File: rtl/interval_timer_channel.sv
module interval_timer_channel #(
  parameter int CHAN_ID  = 0,
  parameter int CNT_W    = 16,
  parameter int STAT_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctl_we,
  input  logic             data_we,
  input  logic             data_re,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             out,
  output logic [7:0]       status_byte,
  output logic             cfg_err
);
  localparam int BYTE_W = CNT_W / 2;
  localparam logic [2:0] M_TC   = 3'd0;
  localparam logic [2:0] M_RATE = 3'd2;
  localparam logic [2:0] M_SQ   = 3'd3;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] count, period, snap, cnt_nxt, src, full;
  logic [2:0]       mode_q;
  logic             out_q, running, latched, rd_hi, wr_hi;
  logic             out_nxt, run_nxt;

  wire [1:0] c_sel  = wdata[7:6];
  wire [1:0] c_rw   = wdata[5:4];
  wire [2:0] c_mode = wdata[3:1];
  wire       c_bcd  = wdata[0];

  wire ctl_hit   = ctl_we && (c_sel == CHAN_ID[1:0]);
  wire ctl_rb    = ctl_we && (c_sel == 2'd3);
  wire ctl_latch = ctl_hit && (c_rw == 2'd0);
  wire mode_ok   = (c_mode == M_TC) || (c_mode == M_RATE) || (c_mode == M_SQ);
  wire ctl_set   = ctl_hit && (c_rw == 2'd3) && mode_ok && !c_bcd;
  wire ctl_bad   = ctl_rb || (ctl_hit && (c_rw != 2'd0) && !ctl_set);

  assign full = {wdata, count[BYTE_W-1:0]};

  always_comb begin
    cnt_nxt = count;
    out_nxt = out_q;
    run_nxt = running;
    if (tick && running) begin
      case (mode_q)
        M_RATE: begin
          if (count == ONE) begin
            cnt_nxt = period;
            out_nxt = 1'b1;
          end else begin
            cnt_nxt = count - ONE;
            out_nxt = (count != TWO);
          end
        end
        M_SQ: begin
          if (count <= TWO) begin
            cnt_nxt = period;
            out_nxt = !out_q;
          end else begin
            cnt_nxt = count - TWO;
          end
        end
        default: begin
          if (count == ONE) begin
            cnt_nxt = '0;
            out_nxt = 1'b1;
            run_nxt = 1'b0;
          end else begin
            cnt_nxt = count - ONE;
          end
        end
      endcase
    end
    if (data_we) begin
      if (!wr_hi) begin
        cnt_nxt = {count[CNT_W-1:BYTE_W], wdata};
        run_nxt = 1'b0;
        out_nxt = 1'b0;
      end else begin
        cnt_nxt = full;
        run_nxt = (full != '0);
        out_nxt = (full != '0) && (mode_q != M_TC);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      period  <= '0;
      snap    <= '0;
      mode_q  <= M_TC;
      out_q   <= 1'b0;
      running <= 1'b0;
      latched <= 1'b0;
      rd_hi   <= 1'b0;
      wr_hi   <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      count   <= cnt_nxt;
      out_q   <= out_nxt;
      running <= run_nxt;
      if (data_we) begin
        wr_hi <= !wr_hi;
        if (wr_hi) period <= full;
      end
      if (data_re) begin
        if (rd_hi) begin
          rd_hi   <= 1'b0;
          latched <= 1'b0;
        end else begin
          rd_hi <= 1'b1;
        end
      end
      if (ctl_latch && !latched) begin
        latched <= 1'b1;
        snap    <= count;
        rd_hi   <= 1'b0;
      end
      if (ctl_set) mode_q <= c_mode;
      if (ctl_bad) cfg_err <= 1'b1;
    end
  end

  assign src         = latched ? snap : count;
  assign rdata       = rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
  assign out         = out_q;
  assign status_byte = {{(BYTE_W-1){1'b0}}, out_q} << STAT_BIT;
endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_we,
  input logic             data_re,
  input logic             ctl_we,
  input logic [7:0]       wdata,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] snap,
  input logic [2:0]       mode_q,
  input logic             out_q,
  input logic             running,
  input logic             latched,
  input logic             rd_hi,
  input logic             wr_hi,
  input logic             cfg_err
);
  assert_low_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !wr_hi) |=> (!out_q && !running));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !data_we) |=> $stable(count));

  assert_zero_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && wr_hi && wdata == 8'h00 && count[7:0] == 8'h00) |=> !running);

  assert_mode0_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && out_q && !data_we) |=> out_q);

  assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_snap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !data_re) |=> (latched && $stable(snap)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && rd_hi && !ctl_we) |=> (!latched && !rd_hi));
endmodule

bind interval_timer_channel itc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_re(data_re),
  .ctl_we(ctl_we), .wdata(wdata), .count(count), .snap(snap),
  .mode_q(mode_q), .out_q(out_q), .running(running), .latched(latched),
  .rd_hi(rd_hi), .wr_hi(wr_hi), .cfg_err(cfg_err)
);

// File: tb/sim_interval_timer_channel.sv
module sim_interval_timer_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, ctl_we = 1'b0, data_we = 1'b0, data_re = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, status_byte;
  logic out, cfg_err;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  interval_timer_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_we(ctl_we),
    .data_we(data_we), .data_re(data_re), .wdata(wdata),
    .rdata(rdata), .out(out), .status_byte(status_byte), .cfg_err(cfg_err)
  );

  // entry: req[24:21] op[20:19] arg[18:11] exp_byte[10:3] exp_out[2] pad[1:0]
  // op 0 = control write, 1 = data write, 2 = read (byte checked), 3 = arg ticks
  localparam int NV = 47;
  localparam logic [24:0] VEC [NV] = '{
    {4'd1,  2'd0, 8'h30, 8'h00, 1'b0, 2'b0},  // R1 mode 0
    {4'd7,  2'd1, 8'h05, 8'h00, 1'b0, 2'b0},  // R7
    {4'd8,  2'd1, 8'h00, 8'h00, 1'b0, 2'b0},  // R8 mode 0 stays low
    {4'd6,  2'd2, 8'h00, 8'h05, 1'b0, 2'b0},  // R6 low byte
    {4'd6,  2'd2, 8'h00, 8'h00, 1'b0, 2'b0},  // R6 high byte
    {4'd9,  2'd3, 8'd4,  8'h00, 1'b0, 2'b0},  // R9
    {4'd9,  2'd3, 8'd1,  8'h00, 1'b1, 2'b0},  // R9 terminal, R12 status
    {4'd9,  2'd3, 8'd3,  8'h00, 1'b1, 2'b0},  // R9 holds
    {4'd9,  2'd2, 8'h00, 8'h00, 1'b1, 2'b0},  // R9 stopped at 0
    {4'd9,  2'd2, 8'h00, 8'h00, 1'b1, 2'b0},
    {4'd1,  2'd0, 8'h34, 8'h00, 1'b1, 2'b0},  // R1 mode 2
    {4'd7,  2'd1, 8'h04, 8'h00, 1'b0, 2'b0},  // R7
    {4'd8,  2'd1, 8'h00, 8'h00, 1'b1, 2'b0},  // R8 mode 2 starts high
    {4'd10, 2'd3, 8'd1,  8'h00, 1'b1, 2'b0},  // R10 count 3
    {4'd4,  2'd0, 8'h00, 8'h00, 1'b1, 2'b0},  // R4 latch 3
    {4'd10, 2'd3, 8'd1,  8'h00, 1'b1, 2'b0},  // R10 count 2
    {4'd10, 2'd3, 8'd1,  8'h00, 1'b0, 2'b0},  // R10 count 1 low
    {4'd5,  2'd0, 8'h00, 8'h00, 1'b0, 2'b0},  // R5 second latch ignored
    {4'd4,  2'd2, 8'h00, 8'h03, 1'b0, 2'b0},  // R4 R5 snapshot low
    {4'd6,  2'd2, 8'h00, 8'h00, 1'b0, 2'b0},  // R6 high releases
    {4'd6,  2'd2, 8'h00, 8'h01, 1'b0, 2'b0},  // R6 live again
    {4'd6,  2'd2, 8'h00, 8'h00, 1'b0, 2'b0},
    {4'd10, 2'd3, 8'd1,  8'h00, 1'b1, 2'b0},  // R10 reload
    {4'd10, 2'd3, 8'd2,  8'h00, 1'b1, 2'b0},
    {4'd10, 2'd3, 8'd1,  8'h00, 1'b0, 2'b0},
    {4'd1,  2'd0, 8'h36, 8'h00, 1'b0, 2'b0},  // R1 mode 3
    {4'd7,  2'd1, 8'h06, 8'h00, 1'b0, 2'b0},
    {4'd8,  2'd1, 8'h00, 8'h00, 1'b1, 2'b0},  // R8 mode 3 starts high
    {4'd11, 2'd3, 8'd2,  8'h00, 1'b1, 2'b0},  // R11 even period
    {4'd11, 2'd3, 8'd1,  8'h00, 1'b0, 2'b0},
    {4'd11, 2'd3, 8'd3,  8'h00, 1'b1, 2'b0},
    {4'd11, 2'd3, 8'd3,  8'h00, 1'b0, 2'b0},
    {4'd7,  2'd1, 8'h05, 8'h00, 1'b0, 2'b0},
    {4'd8,  2'd1, 8'h00, 8'h00, 1'b1, 2'b0},
    {4'd11, 2'd3, 8'd2,  8'h00, 1'b1, 2'b0},  // R11 odd period
    {4'd11, 2'd3, 8'd1,  8'h00, 1'b0, 2'b0},
    {4'd11, 2'd3, 8'd3,  8'h00, 1'b1, 2'b0},
    {4'd7,  2'd1, 8'h08, 8'h00, 1'b0, 2'b0},  // R7 forces low, stops
    {4'd7,  2'd3, 8'd5,  8'h00, 1'b0, 2'b0},
    {4'd7,  2'd2, 8'h00, 8'h08, 1'b0, 2'b0},
    {4'd7,  2'd2, 8'h00, 8'h00, 1'b0, 2'b0},
    {4'd8,  2'd1, 8'h00, 8'h00, 1'b1, 2'b0},  // R8 count 8 starts
    {4'd7,  2'd1, 8'h00, 8'h00, 1'b0, 2'b0},
    {4'd8,  2'd1, 8'h00, 8'h00, 1'b0, 2'b0},  // R8 zero does not start
    {4'd8,  2'd3, 8'd6,  8'h00, 1'b0, 2'b0},
    {4'd8,  2'd2, 8'h00, 8'h00, 1'b0, 2'b0},
    {4'd8,  2'd2, 8'h00, 8'h00, 1'b0, 2'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic ctl(input logic [7:0] b);
    @(negedge clk) begin ctl_we = 1'b1; wdata = b; end
    @(negedge clk) ctl_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk) begin data_we = 1'b1; wdata = b; end
    @(negedge clk) data_we = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    @(negedge clk) begin b = rdata; data_re = 1'b1; end
    @(negedge clk) data_re = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
    end
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        report();
      end
    end
  end

  initial begin
    logic [7:0] b;
    logic [24:0] e;
    do_reset();
    @(negedge clk);
    check("R13 out", {7'b0, out}, 8'h00);
    check("R13 cfg_err", {7'b0, cfg_err}, 8'h00);
    check("R13 rdata", rdata, 8'h00);
    check("R13 status", status_byte, 8'h00);

    for (int i = 0; i < NV; i++) begin
      e = VEC[i];
      case (e[20:19])
        2'd0: ctl(e[18:11]);
        2'd1: wr(e[18:11]);
        2'd2: begin
          rd(b);
          check($sformatf("R%0d read vec %0d", e[24:21], i), b, e[10:3]);
        end
        default: ticks(int'(e[18:11]));
      endcase
      check($sformatf("R%0d out vec %0d", e[24:21], i), {7'b0, out}, {7'b0, e[2]});
      if (e[20:19] == 2'd3)
        check($sformatf("R12 status vec %0d", i), status_byte, {2'b0, e[2], 5'b0});
    end
    check("R1 no error after valid words", {7'b0, cfg_err}, 8'h00);

    // R2 read-back select
    do_reset();
    ctl(8'hC0);
    check("R2 read-back", {7'b0, cfg_err}, 8'h01);
    ticks(3);
    check("R2 sticky", {7'b0, cfg_err}, 8'h01);
    do_reset();
    check("R13 error cleared", {7'b0, cfg_err}, 8'h00);
    ctl(8'h12);
    check("R2 low-only access", {7'b0, cfg_err}, 8'h01);
    do_reset();
    ctl(8'h31);
    check("R2 bcd", {7'b0, cfg_err}, 8'h01);
    do_reset();
    ctl(8'h36);
    ctl(8'h32);
    check("R2 mode 1 refused", {7'b0, cfg_err}, 8'h01);
    wr(8'h02); wr(8'h00);
    check("R2 mode kept (mode 3 starts high)", {7'b0, out}, 8'h01);

    // R3 other channel ignored
    do_reset();
    ctl(8'h76);
    check("R3 no error", {7'b0, cfg_err}, 8'h00);
    wr(8'h02); wr(8'h00);
    check("R3 still mode 0", {7'b0, out}, 8'h00);
    ticks(2);
    check("R3 mode 0 terminal", {7'b0, out}, 8'h01);
    ticks(4);
    check("R3 mode 0 holds", {7'b0, out}, 8'h01);
    ctl(8'h40);
    rd(b);
    check("R3 other-channel latch ignored", b, 8'h00);

    done = 1'b1;
    report();
  end
endmodule